// File: doc/BRIEF.md
# Half-Group Memory Access Coalescer

This block sits between a group of sixteen threads (half of a 32-thread execution group) and the memory system. Each incoming request carries a per-thread active mask, one byte address per thread and a word-size code. The block decides whether the whole request forms the strict ordered, aligned pattern. If it does, it is served as one wide transaction, or two for 128-bit words. If it does not, it is broken into one narrow transaction for each active thread.

Coalescing is all-or-nothing. Every active thread k must address word k of a naturally aligned span of sixteen words. Threads that are masked off do not count against the pattern. A single swapped address or a misaligned span base sends the whole request down the split path. The block does not try to group addresses into partial segments. Transactions leave on a valid/ready stream. A new request is accepted only once the previous one has drained.

Top module: `halfgroup_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1 and `txn_valid` is 0.
- R2: With word code 0 (4-byte words), if every active lane k addresses B + 4k and B is a multiple of 64, exactly one transaction is issued. It has address B, size 64 bytes and mask equal to the request mask.
- R3: With word code 1 (8-byte words), if every active lane k addresses B + 8k and B is a multiple of 128, exactly one transaction is issued. It has address B, size 128 bytes and mask equal to the request mask.
- R4: With word code 2 (16-byte words), if every active lane k addresses B + 16k and B is a multiple of 256, up to two transactions are issued. The first has address B, size 128 and mask = request mask AND 0x00FF. The second has address B+128, size 128 and mask = request mask AND 0xFF00. A half whose mask is zero issues nothing. Word code 3 behaves exactly as code 2.
- R5: The addresses on lanes whose mask bit is 0 have no effect on the coalescing decision or on the transactions issued.
- R6: If any active lane breaks the ordered pattern, one transaction is issued per active lane in ascending lane order. Each has that lane's address, size 4 << code bytes (16 for codes 2 and 3), and a mask with only that lane's bit set.
- R7: An ordered pattern whose span base is not a multiple of the span size (64, 128 or 256 bytes for codes 0, 1, 2) is split exactly as in R6.
- R8: A request with an all-zero mask is accepted, issues no transaction, and leaves `req_ready` at 1 on the following cycle.
- R9: `req_ready` is 0 from the cycle after a request with a non-zero mask is accepted. It returns to 1 in the cycle after the last transaction of that request is accepted.
- R10: While `txn_valid` is 1 and `txn_ready` is 0, `txn_valid`, `txn_addr`, `txn_bytes` and `txn_mask` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_mask | input | LANES | Per-lane active bits |
| req_wsize | input | 2 | Word size code: 0 = 4 B, 1 = 8 B, 2 and 3 = 16 B |
| req_addr | input | LANES*ADDR_W | Lane k byte address in bits [k*ADDR_W +: ADDR_W] |
| txn_valid | output | 1 | Transaction present |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_addr | output | ADDR_W | Transaction byte address |
| txn_bytes | output | $clog2(LANES*8)+1 | Transaction size in bytes |
| txn_mask | output | LANES | Lanes served by this transaction |

## Verification
Fully active ordered requests at all three word sizes check the wide path and the two-half split for the largest word. Sparse masks check that a half with no live lanes is dropped. Requests with garbage addresses on inactive lanes must still coalesce. This separates a design that tests only live lanes from one that tests all sixteen. Swapped lane pairs and spans shifted off their boundary must both produce the per-lane sequence in lane order. These cases tell the ordering test apart from the alignment test, and include a base aligned to 128 bytes but not to 256 for the largest word. An empty mask, the reserved size code and a stalled downstream test request acceptance and output holding.

// File: rtl/cz_pkg.sv
package cz_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } cz_state_e;

  localparam logic [1:0] WS_W4  = 2'd0;
  localparam logic [1:0] WS_W8  = 2'd1;
  localparam logic [1:0] WS_W16 = 2'd2;
endpackage

// File: rtl/cz_rst_sync.sv
module cz_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/cz_pattern_check.sv
module cz_pattern_check #(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [LANES-1:0]        mask,
  input  logic [LANES*ADDR_W-1:0] addr_flat,
  input  logic [1:0]              wsize,
  output logic                    coal,
  output logic [ADDR_W-1:0]       base
);
  logic [ADDR_W-1:0] lane_addr [LANES];
  logic [7:0]        span_lg;
  logic [7:0]        word_lg;
  logic [ADDR_W-1:0] low_mask;
  logic [ADDR_W-1:0] hi_ref;

  for (genvar g = 0; g < LANES; g++) begin : g_unpack
    assign lane_addr[g] = addr_flat[g*ADDR_W +: ADDR_W];
  end

  always_comb begin
    word_lg  = 8'd2 + {6'b0, wsize};
    span_lg  = 8'(LANE_W) + word_lg;
    low_mask = ~({ADDR_W{1'b1}} << span_lg);
    hi_ref   = '0;
    for (int k = 0; k < LANES; k++) begin
      if (mask[k]) begin
        hi_ref = hi_ref | (lane_addr[k] & ~low_mask);
      end
    end
    coal = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      if (mask[k]) begin
        if ((lane_addr[k] & low_mask) != (ADDR_W'(k) << word_lg)) begin
          coal = 1'b0;
        end
        if ((lane_addr[k] & ~low_mask) != hi_ref) begin
          coal = 1'b0;
        end
      end
    end
    base = hi_ref;
  end
endmodule

// File: rtl/cz_lane_pick.sv
module cz_lane_pick #(
  parameter int LANES = 16,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [LANES-1:0]  vec,
  output logic [LANE_W-1:0] idx,
  output logic [LANES-1:0]  onehot,
  output logic              any
);
  always_comb begin
    idx = '0;
    any = |vec;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (vec[k]) begin
        idx = LANE_W'(k);
      end
    end
    onehot = any ? (LANES'(1) << idx) : '0;
  end
endmodule

// File: rtl/cz_issue_seq.sv
module cz_issue_seq
  import cz_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32,
  localparam int LANE_W  = $clog2(LANES),
  localparam int BYTES_W = $clog2(LANES*8) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES-1:0]        req_mask,
  input  logic [1:0]              req_wsize,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  input  logic                    chk_coal,
  input  logic [ADDR_W-1:0]       chk_base,
  output logic                    txn_valid,
  input  logic                    txn_ready,
  output logic [ADDR_W-1:0]       txn_addr,
  output logic [BYTES_W-1:0]      txn_bytes,
  output logic [LANES-1:0]        txn_mask
);
  localparam logic [LANES-1:0] LOW_HALF = {{(LANES/2){1'b0}}, {(LANES/2){1'b1}}};

  cz_state_e               st_q, st_d;
  logic [LANES-1:0]        rem_q, rem_d;
  logic [LANES-1:0]        mask_q;
  logic [1:0]              ws_q;
  logic                    coal_q;
  logic [ADDR_W-1:0]       base_q;
  logic [LANES*ADDR_W-1:0] addr_q;

  logic                    load_en;
  logic                    step_en;
  logic [LANES-1:0]        rem_after;
  logic [LANE_W-1:0]       pk_idx;
  logic [LANES-1:0]        pk_onehot;
  logic                    pk_any;
  logic                    upper_half;

  cz_lane_pick #(.LANES(LANES)) u_pick (
    .vec    (rem_q),
    .idx    (pk_idx),
    .onehot (pk_onehot),
    .any    (pk_any)
  );

  assign req_ready  = (st_q == ST_IDLE);
  assign load_en    = req_valid && req_ready && (|req_mask);
  assign step_en    = txn_valid && txn_ready;
  assign upper_half = pk_idx[LANE_W-1];

  // transaction formation
  always_comb begin
    txn_valid = (st_q == ST_BUSY) && pk_any;
    if (!coal_q) begin
      txn_mask  = pk_onehot;
      txn_addr  = addr_q[pk_idx*ADDR_W +: ADDR_W];
      txn_bytes = BYTES_W'(4) << ws_q;
    end else if (ws_q == WS_W16) begin
      txn_mask  = rem_q & (upper_half ? ~LOW_HALF : LOW_HALF);
      txn_addr  = base_q + (upper_half ? ADDR_W'(LANES*8) : '0);
      txn_bytes = BYTES_W'(LANES*8);
    end else begin
      txn_mask  = rem_q;
      txn_addr  = base_q;
      txn_bytes = BYTES_W'(LANES*4) << ws_q;
    end
  end

  // next state
  always_comb begin
    rem_after = rem_q & ~txn_mask;
    st_d      = st_q;
    rem_d     = rem_q;
    if (load_en) begin
      st_d  = ST_BUSY;
      rem_d = req_mask;
    end else if (step_en) begin
      rem_d = rem_after;
      if (rem_after == '0) begin
        st_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) begin
      mask_q <= req_mask;
      ws_q   <= req_wsize;
      coal_q <= chk_coal;
      base_q <= chk_base;
      addr_q <= req_addr;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_ready |=> txn_valid && $stable(txn_addr) && $stable(txn_bytes) && $stable(txn_mask)); // R10
  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> !req_ready); // R9
  AST_MASK_WITHIN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |-> ((txn_mask & ~mask_q) == '0) && (txn_mask != '0)); // R5
  AST_SPLIT_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !coal_q |-> $onehot(txn_mask)); // R6
  AST_WIDE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && coal_q |-> ((txn_addr & (ADDR_W'(txn_bytes) - 1'b1)) == '0)); // R7
  AST_EMPTY_NO_TXN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_mask == '0) |=> !txn_valid && req_ready); // R8
endmodule

// File: rtl/halfgroup_coalescer.sv
module halfgroup_coalescer #(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32,
  localparam int BYTES_W = $clog2(LANES*8) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES-1:0]        req_mask,
  input  logic [1:0]              req_wsize,
  input  logic [LANES*ADDR_W-1:0] req_addr,
  output logic                    txn_valid,
  input  logic                    txn_ready,
  output logic [ADDR_W-1:0]       txn_addr,
  output logic [BYTES_W-1:0]      txn_bytes,
  output logic [LANES-1:0]        txn_mask
);
  logic              rst_sn;
  logic [1:0]        ws_eff;
  logic              chk_coal;
  logic [ADDR_W-1:0] chk_base;

  assign ws_eff = (req_wsize == 2'd3) ? cz_pkg::WS_W16 : req_wsize;

  cz_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_sn)
  );

  cz_pattern_check #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
    .mask      (req_mask),
    .addr_flat (req_addr),
    .wsize     (ws_eff),
    .coal      (chk_coal),
    .base      (chk_base)
  );

  cz_issue_seq #(.LANES(LANES), .ADDR_W(ADDR_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sn),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mask  (req_mask),
    .req_wsize (ws_eff),
    .req_addr  (req_addr),
    .chk_coal  (chk_coal),
    .chk_base  (chk_base),
    .txn_valid (txn_valid),
    .txn_ready (txn_ready),
    .txn_addr  (txn_addr),
    .txn_bytes (txn_bytes),
    .txn_mask  (txn_mask)
  );
endmodule

// File: tb/halfgroup_coalescer_tb.sv
module halfgroup_coalescer_tb;
  localparam int LANES   = 16;
  localparam int ADDR_W  = 32;
  localparam int BYTES_W = $clog2(LANES*8) + 1;
  localparam int NVEC    = 12;

  // fields: [51:36] mask, [35:34] size code, [33:2] base, [1:0] kind
  // kind 0 ordered, 1 lanes 2/3 swapped, 3 junk on inactive lanes
  localparam logic [51:0] VEC [NVEC] = '{
    {16'hFFFF, 2'd0, 32'h0000_1000, 2'd0},
    {16'hFFFF, 2'd1, 32'h0000_2000, 2'd0},
    {16'hFFFF, 2'd2, 32'h0000_3000, 2'd0},
    {16'h00F0, 2'd2, 32'h0000_3000, 2'd0},
    {16'hF00F, 2'd0, 32'h0000_4000, 2'd3},
    {16'hFFFF, 2'd0, 32'h0000_5000, 2'd1},
    {16'h0F0F, 2'd1, 32'h0000_6000, 2'd1},
    {16'hFFFF, 2'd0, 32'h0000_7020, 2'd0},
    {16'hFFFF, 2'd2, 32'h0000_8080, 2'd0},
    {16'h0000, 2'd0, 32'h0000_9000, 2'd0},
    {16'h8001, 2'd1, 32'h0000_A000, 2'd0},
    {16'hFFFF, 2'd3, 32'h0000_B000, 2'd0}
  };

  logic                    clk;
  logic                    rst_n;
  logic                    req_valid;
  logic                    req_ready;
  logic [LANES-1:0]        req_mask;
  logic [1:0]              req_wsize;
  logic [LANES*ADDR_W-1:0] req_addr;
  logic                    txn_valid;
  logic                    txn_ready;
  logic [ADDR_W-1:0]       txn_addr;
  logic [BYTES_W-1:0]      txn_bytes;
  logic [LANES-1:0]        txn_mask;

  int n_checks;
  int n_fails;
  int cyc;
  bit done;

  logic [ADDR_W-1:0]  exp_addr  [LANES];
  logic [BYTES_W-1:0] exp_bytes [LANES];
  logic [LANES-1:0]   exp_mask  [LANES];
  int                 exp_n;
  string              vtag [NVEC];

  halfgroup_coalescer #(.LANES(LANES), .ADDR_W(ADDR_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_mask  (req_mask),
    .req_wsize (req_wsize),
    .req_addr  (req_addr),
    .txn_valid (txn_valid),
    .txn_ready (txn_ready),
    .txn_addr  (txn_addr),
    .txn_bytes (txn_bytes),
    .txn_mask  (txn_mask)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000 && !done) begin
      done = 1'b1;
      n_fails = n_fails + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 50000", cyc);
      summary_and_end();
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    n_checks = n_checks + 1;
    if (!ok) begin
      n_fails = n_fails + 1;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // independent model of the expected transaction list
  task automatic build_expect(input logic [LANES-1:0] m, input logic [1:0] code,
                              input logic [LANES*ADDR_W-1:0] af);
    int wb;
    int first;
    logic [ADDR_W-1:0] b;
    bit ok;
    int sc;
    sc = (code == 2'd3) ? 2 : int'(code);
    wb = 4 << sc;
    exp_n = 0;
    first = -1;
    for (int k = 0; k < LANES; k++) if (m[k] && first < 0) first = k;
    if (first < 0) return;
    b = af[first*ADDR_W +: ADDR_W] - ADDR_W'(first * wb);
    ok = ((b % (16 * wb)) == 0);
    for (int k = 0; k < LANES; k++)
      if (m[k] && af[k*ADDR_W +: ADDR_W] != b + ADDR_W'(k * wb)) ok = 0;
    if (ok && sc < 2) begin
      exp_addr[0] = b; exp_bytes[0] = BYTES_W'(16 * wb); exp_mask[0] = m; exp_n = 1;
    end else if (ok) begin
      if ((m & 16'h00FF) != 0) begin
        exp_addr[exp_n] = b; exp_bytes[exp_n] = 128; exp_mask[exp_n] = m & 16'h00FF; exp_n++;
      end
      if ((m & 16'hFF00) != 0) begin
        exp_addr[exp_n] = b + 128; exp_bytes[exp_n] = 128; exp_mask[exp_n] = m & 16'hFF00; exp_n++;
      end
    end else begin
      for (int k = 0; k < LANES; k++) begin
        if (m[k]) begin
          exp_addr[exp_n]  = af[k*ADDR_W +: ADDR_W];
          exp_bytes[exp_n] = BYTES_W'(wb);
          exp_mask[exp_n]  = LANES'(1) << k;
          exp_n++;
        end
      end
    end
  endtask

  task automatic run_req(input logic [51:0] v, input string tag, input int stall);
    logic [LANES-1:0]        m;
    logic [1:0]              code;
    logic [ADDR_W-1:0]       b;
    logic [1:0]              kind;
    logic [LANES*ADDR_W-1:0] af;
    logic [ADDR_W-1:0]       tmp;
    logic [ADDR_W-1:0]       h_addr;
    logic [LANES-1:0]        h_mask;
    logic [BYTES_W-1:0]      h_bytes;
    int wb;
    int got;
    int guard;
    m = v[51:36]; code = v[35:34]; b = v[33:2]; kind = v[1:0];
    wb = 4 << ((code == 2'd3) ? 2 : int'(code));
    for (int k = 0; k < LANES; k++) begin
      af[k*ADDR_W +: ADDR_W] = b + ADDR_W'(k * wb);
      if (kind == 2'd3 && !m[k]) af[k*ADDR_W +: ADDR_W] = 32'hDEAD_0000 + ADDR_W'(k * 7);
    end
    if (kind == 2'd1) begin
      tmp = af[2*ADDR_W +: ADDR_W];
      af[2*ADDR_W +: ADDR_W] = af[3*ADDR_W +: ADDR_W];
      af[3*ADDR_W +: ADDR_W] = tmp;
    end
    build_expect(m, code, af);
    @(negedge clk);
    req_valid = 1'b1; req_mask = m; req_wsize = code; req_addr = af;
    txn_ready = (stall == 0);
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = '1;
    if (exp_n > 0) chk(req_ready == 1'b0, {tag, " R9 busy"}, req_ready, 0);
    if (stall > 0 && exp_n > 0) begin
      h_addr = txn_addr; h_mask = txn_mask; h_bytes = txn_bytes;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk(txn_valid && txn_addr == h_addr && txn_mask == h_mask && txn_bytes == h_bytes,
            "R10 hold", {txn_addr, 16'(txn_mask)}, {h_addr, 16'(h_mask)});
      end
      txn_ready = 1'b1;
    end
    got = 0;
    guard = 0;
    while (got < exp_n && guard < 100) begin
      if (txn_valid) begin
        chk(txn_addr == exp_addr[got] && txn_bytes == exp_bytes[got] && txn_mask == exp_mask[got],
            tag, {txn_addr, 8'(txn_bytes), 16'(txn_mask)},
            {exp_addr[got], 8'(exp_bytes[got]), 16'(exp_mask[got])});
        got++;
      end
      guard++;
      @(negedge clk);
    end
    chk(got == exp_n, {tag, " count"}, got, exp_n);
    chk(!txn_valid, {tag, " drained"}, txn_valid, 0);
    chk(req_ready, {tag, " R9 ready again"}, req_ready, 1);
  endtask

  initial begin
    n_checks = 0; n_fails = 0; cyc = 0; done = 1'b0;
    vtag = '{"R2", "R3", "R4", "R4", "R5", "R6", "R6", "R7", "R7", "R8", "R3", "R4 code3"};
    rst_n = 1'b0; req_valid = 1'b0; req_mask = '0; req_wsize = '0; req_addr = '0; txn_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && txn_valid == 1'b0, "R1 in reset", {req_ready, txn_valid}, 2'b10);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1 && txn_valid == 1'b0, "R1 after reset", {req_ready, txn_valid}, 2'b10);

    for (int i = 0; i < NVEC; i++) run_req(VEC[i], vtag[i], 0);

    // stalled downstream on a split request
    run_req({16'hFFFF, 2'd0, 32'h0000_C000, 2'd1}, "R10 split", 3);
    // stalled downstream on a two-half wide request
    run_req({16'h0FF0, 2'd2, 32'h0000_D000, 2'd0}, "R10 wide", 2);
    // junk addresses on inactive lanes of a sparse 8-byte request
    run_req({16'h00FF, 2'd1, 32'h0000_E000, 2'd3}, "R5 sparse", 0);

    done = 1'b1;
    summary_and_end();
  end
endmodule